// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block is the intake stage of a display controller. A memory fetcher hands it a stream of 32-bit words. Depending on a two-bit load mode, the block treats the start of that stream as a color lookup table, treats the whole stream as frame pixel data, or does the table first and then the frame. The first table word carries a depth code in a header nibble. That code sets how many words the table fetch lasts and whether pixel lookups go through the table.

Each table word holds two halfword entries, and each entry holds a 12-bit RGB444 color (red 11:8, green 7:4, blue 3:0). Up to 256 entries are kept in an internal table. When the final table word arrives, a palette-loaded flag goes high. After that, a lookup port turns 8-bit pixel indices into colors. Whether software may clear the flag depends on the load mode.

Top module: `pal_frame_loader`

## Requirements
- R1: A pulse on `ctrlWr` with `ctrlEnable`=1 starts a new load and clears `paletteLoaded`. `ctrlMode` 2'b00 loads the table and then the frame, 2'b01 loads only the table, 2'b10 loads only the frame, and 2'b11 starts nothing, so incoming words are ignored.
- R2: In mode 2'b00, every word accepted after the final table word appears on `frameData` with `frameValid` high one cycle later. The table words themselves never reach the frame output.
- R3: In mode 2'b01, words that arrive after the table is complete are ignored, so `frameValid` stays low.
- R4: In mode 2'b10, every accepted word appears on the frame output one cycle later, and `paletteLoaded` stays low.
- R5: Bits 15:12 of the first table word give the depth code (0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=12/16 bpp), shown on `depthCode`. Code 4 means a 32-byte table, fetched as 9 words. Every other code means a 512-byte table, fetched as 129 words.
- R6: Table word n writes its bits 11:0 to entry 2n and its bits 27:16 to entry 2n+1. The header nibbles (bits 15:12 and 31:28) are not stored, and halfwords beyond entry 255 are dropped.
- R7: `paletteLoaded` goes high in the cycle after the last table word is accepted, and not before.
- R8: A `statusClr` pulse clears `paletteLoaded` only when the current mode is 2'b01. In modes 2'b00 and 2'b10 the pulse has no effect.
- R9: A `ctrlWr` with `ctrlEnable`=0 clears `paletteLoaded` and stops the load, so later words produce no frame output.
- R10: When the depth code is not 4, `pixOut` equals {4'h0, entry[`pixIn`[7:0]]} one cycle after `pixIn` is presented.
- R11: When the depth code is 4, `pixOut` equals `pixIn` one cycle later, and the table is bypassed.
- R12: After reset, `paletteLoaded`, `frameValid`, `depthCode` and `pixOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlEnable | input | 1 | Enable bit of the control write |
| ctrlMode | input | 2 | Load mode of the control write |
| statusClr | input | 1 | Request to clear the loaded flag |
| wordValid | input | 1 | Fetched word present |
| wordData | input | 32 | Fetched word |
| frameValid | output | 1 | Frame word present |
| frameData | output | 32 | Frame word |
| paletteLoaded | output | 1 | Table load complete |
| depthCode | output | 4 | Latched depth code |
| pixIn | input | 16 | Pixel index, or raw pixel in bypass |
| pixOut | output | 16 | Looked-up color, or bypassed pixel |

## Verification
Three results are due exactly one cycle after their cause: the frame word after its input word, the lookup result after its index, and the loaded flag after the final table word. The flag is also sampled one word earlier to confirm it has not risen too soon. Inputs change on the falling edge. Frame and flag checks are taken at the next falling edge. Lookups go through a scoreboard queue: the driver pushes the expected value, and the monitor pops it at the rising edge that samples the index and compares it a quarter period later.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam logic [1:0] MODE_BOTH     = 2'b00;
  localparam logic [1:0] MODE_PAL_ONLY = 2'b01;
  localparam logic [1:0] MODE_FRM_ONLY = 2'b10;
  localparam logic [3:0] SHORT_CODE    = 4'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_PAL, ST_HOLD, ST_FRAME} lseqState_t;

  typedef struct packed {
    logic wrPair;
    logic takeHeader;
    logic passFrame;
  } lseqStrobe_t;
endpackage

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int LONG_WORDS  = 129,
  parameter int SHORT_WORDS = 9,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             ctrlEnable,
  input  logic [1:0]       ctrlMode,
  input  logic             statusClr,
  input  logic             wordValid,
  input  logic [3:0]       wordHdr,
  output lseqStrobe_t      strobe,
  output logic [CNT_W-1:0] wordCnt,
  output logic             paletteLoaded
);
  lseqState_t state;
  logic [1:0] modeReg;
  logic       shortPal;
  logic       isFirst, curShort, lastWord, takeWord;

  always_comb begin
    isFirst  = (wordCnt == '0);
    curShort = isFirst ? (wordHdr == SHORT_CODE) : shortPal;
    lastWord = curShort ? (wordCnt == CNT_W'(SHORT_WORDS - 1))
                        : (wordCnt == CNT_W'(LONG_WORDS - 1));
    takeWord = wordValid && !ctrlWr;
    strobe.wrPair     = (state == ST_PAL) && takeWord;
    strobe.takeHeader = (state == ST_PAL) && takeWord && isFirst;
    strobe.passFrame  = (state == ST_FRAME) && takeWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      modeReg       <= MODE_BOTH;
      wordCnt       <= '0;
      shortPal      <= 1'b0;
      paletteLoaded <= 1'b0;
    end else if (ctrlWr) begin
      modeReg       <= ctrlMode;
      wordCnt       <= '0;
      paletteLoaded <= 1'b0;
      if (!ctrlEnable) state <= ST_IDLE;
      else begin
        case (ctrlMode)
          MODE_BOTH, MODE_PAL_ONLY: state <= ST_PAL;
          MODE_FRM_ONLY:            state <= ST_FRAME;
          default:                  state <= ST_IDLE;
        endcase
      end
    end else begin
      if (statusClr && modeReg == MODE_PAL_ONLY) paletteLoaded <= 1'b0;
      if (strobe.wrPair) begin
        if (isFirst) shortPal <= curShort;
        if (lastWord) begin
          paletteLoaded <= 1'b1;
          state <= (modeReg == MODE_PAL_ONLY) ? ST_HOLD : ST_FRAME;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
    end
  end

  // R7
  loaded_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paletteLoaded) |-> $past(state == ST_PAL && wordValid));
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !ctrlEnable) |=> (!paletteLoaded && state == ST_IDLE));
  // R8
  clr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !ctrlWr && modeReg != MODE_PAL_ONLY && paletteLoaded) |=> paletteLoaded);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAL) |-> (wordCnt < CNT_W'(LONG_WORDS)));
endmodule

// File: rtl/lseq_datapath.sv
module lseq_datapath
  import lseq_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int ENTRY_W = 12,
  parameter int HALF_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  lseqStrobe_t         strobe,
  input  logic [CNT_W-1:0]    wordCnt,
  input  logic [2*HALF_W-1:0] wordData,
  input  logic [HALF_W-1:0]   pixIn,
  output logic                frameValid,
  output logic [2*HALF_W-1:0] frameData,
  output logic [3:0]          depthCode,
  output logic [HALF_W-1:0]   pixOut
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRY_W-1:0] lut [ENTRIES];
  logic [CNT_W:0]     hwIdx [2];
  logic [1:0]         wrOk;
  logic               bypass;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      hwIdx[h] = {wordCnt, 1'(h)};
      wrOk[h]  = (32'(hwIdx[h]) < ENTRIES);
    end
    bypass = (depthCode == SHORT_CODE);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrPair) begin
      for (int h = 0; h < 2; h++) begin
        if (wrOk[h]) lut[hwIdx[h][IDX_W-1:0]] <= wordData[h*HALF_W +: ENTRY_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthCode  <= '0;
      frameValid <= 1'b0;
      frameData  <= '0;
      pixOut     <= '0;
    end else begin
      if (strobe.takeHeader) depthCode <= wordData[HALF_W-1 -: 4];
      frameValid <= strobe.passFrame;
      if (strobe.passFrame) frameData <= wordData;
      pixOut <= bypass ? pixIn : HALF_W'(lut[pixIn[IDX_W-1:0]]);
    end
  end

  // R5
  depth_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.takeHeader) |-> $stable(depthCode));
  // R10
  zero_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bypass) |-> (pixOut[HALF_W-1:ENTRY_W] == '0));
endmodule

// File: rtl/pal_frame_loader.sv
module pal_frame_loader
  import lseq_pkg::*;
#(
  parameter int ENTRIES     = 256,
  parameter int ENTRY_W     = 12,
  parameter int HALF_W      = 16,
  parameter int LONG_BYTES  = 512,
  parameter int SHORT_BYTES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic                ctrlEnable,
  input  logic [1:0]          ctrlMode,
  input  logic                statusClr,
  input  logic                wordValid,
  input  logic [2*HALF_W-1:0] wordData,
  output logic                frameValid,
  output logic [2*HALF_W-1:0] frameData,
  output logic                paletteLoaded,
  output logic [3:0]          depthCode,
  input  logic [HALF_W-1:0]   pixIn,
  output logic [HALF_W-1:0]   pixOut
);
  localparam int LONG_WORDS  = LONG_BYTES / 4 + 1;
  localparam int SHORT_WORDS = SHORT_BYTES / 4 + 1;
  localparam int CNT_W       = $clog2(LONG_WORDS);

  lseqStrobe_t      strobe;
  logic [CNT_W-1:0] wordCnt;

  lseq_ctrl #(.LONG_WORDS(LONG_WORDS), .SHORT_WORDS(SHORT_WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlEnable(ctrlEnable), .ctrlMode(ctrlMode),
    .statusClr(statusClr), .wordValid(wordValid), .wordHdr(wordData[HALF_W-1 -: 4]),
    .strobe(strobe), .wordCnt(wordCnt), .paletteLoaded(paletteLoaded)
  );

  lseq_datapath #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .HALF_W(HALF_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordCnt(wordCnt), .wordData(wordData),
    .pixIn(pixIn), .frameValid(frameValid), .frameData(frameData),
    .depthCode(depthCode), .pixOut(pixOut)
  );
endmodule

// File: tb/pal_frame_loader_tb.sv
module pal_frame_loader_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0, ctrlEnable = 1'b0, statusClr = 1'b0, wordValid = 1'b0;
  logic [1:0]  ctrlMode = 2'b00;
  logic [31:0] wordData = '0;
  logic [15:0] pixIn = '0;
  logic        frameValid, paletteLoaded;
  logic [31:0] frameData;
  logic [3:0]  depthCode;
  logic [15:0] pixOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [11:0] model [256];
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  pal_frame_loader u_dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlEnable(ctrlEnable), .ctrlMode(ctrlMode),
    .statusClr(statusClr), .wordValid(wordValid), .wordData(wordData),
    .frameValid(frameValid), .frameData(frameData), .paletteLoaded(paletteLoaded),
    .depthCode(depthCode), .pixIn(pixIn), .pixOut(pixOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] col(input int k, input int s);
    return 12'((k * 37 + s * 101 + 5) & 12'hfff);
  endfunction

  task automatic ctrlWrite(input logic en, input logic [1:0] mode);
    ctrlWr = 1'b1; ctrlEnable = en; ctrlMode = mode;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    wordValid = 1'b1; wordData = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic pulseClr();
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
  endtask

  task automatic loadPalette(input logic [3:0] code, input int s, input int nWords);
    for (int n = 0; n < nWords; n++) begin
      logic [15:0] lo, hi;
      lo = {(n == 0) ? code : 4'(n), col(2 * n, s)};
      hi = {4'hA, col(2 * n + 1, s)};
      if (2 * n < 256)     model[2 * n]     = col(2 * n, s);
      if (2 * n + 1 < 256) model[2 * n + 1] = col(2 * n + 1, s);
      sendWord({hi, lo});
      if (n == nWords - 2) chk("R7 loaded not early", 32'(paletteLoaded), 32'd0);
      if (n < nWords - 1 || n == nWords - 1) chk("R2 no frame during table", 32'(frameValid), 32'd0);
    end
    chk("R7 loaded after last word", 32'(paletteLoaded), 32'd1);
  endtask

  task automatic lookup(input logic [15:0] v, input logic [15:0] exp, input string tag);
    pixIn = v;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      #5 chk(t, 32'(pixOut), 32'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 loaded reset", 32'(paletteLoaded), 32'd0);
    chk("R12 frameValid reset", 32'(frameValid), 32'd0);
    chk("R12 depth reset", 32'(depthCode), 32'd0);
    chk("R12 pixOut reset", 32'(pixOut), 32'd0);

    // combined mode, 8 bpp, long table
    ctrlWrite(1'b1, 2'b00);
    loadPalette(4'd3, 1, 129);
    chk("R5 depth code 3", 32'(depthCode), 32'd3);
    lookup(16'd0,   {4'h0, model[0]},   "R6 entry0 header stripped");
    lookup(16'd1,   {4'h0, model[1]},   "R6 entry1 high half");
    lookup(16'd128, {4'h0, model[128]}, "R10 entry128");
    lookup(16'h00FF, {4'h0, model[255]}, "R10 entry255");
    lookup(16'hFF07, {4'h0, model[7]},  "R10 upper index bits ignored");
    sendWord(32'h1234_5678);
    chk("R2 frameValid", 32'(frameValid), 32'd1);
    chk("R2 frameData", frameData, 32'h1234_5678);
    sendWord(32'hCAFE_0001);
    chk("R2 frameData second", frameData, 32'hCAFE_0001);
    pulseClr();
    chk("R8 clear ignored in mode 00", 32'(paletteLoaded), 32'd1);
    ctrlWrite(1'b0, 2'b00);
    chk("R9 disable clears loaded", 32'(paletteLoaded), 32'd0);
    sendWord(32'h5555_AAAA);
    chk("R9 no frame after disable", 32'(frameValid), 32'd0);

    // palette only, 16 bpp, short table
    ctrlWrite(1'b1, 2'b01);
    loadPalette(4'd4, 2, 9);
    chk("R5 depth code 4", 32'(depthCode), 32'd4);
    sendWord(32'h0BAD_F00D);
    chk("R3 words ignored after table", 32'(frameValid), 32'd0);
    lookup(16'hABCD, 16'hABCD, "R11 bypass");
    lookup(16'h0003, 16'h0003, "R11 bypass low");
    pulseClr();
    chk("R8 clear in mode 01", 32'(paletteLoaded), 32'd0);

    // palette only, 1 bpp, new contents
    ctrlWrite(1'b1, 2'b01);
    loadPalette(4'd0, 3, 129);
    chk("R5 depth code 0", 32'(depthCode), 32'd0);
    lookup(16'd17,  {4'h0, model[17]},  "R6 entry17 reloaded");
    lookup(16'd255, {4'h0, model[255]}, "R6 last entry");

    // frame only
    ctrlWrite(1'b1, 2'b10);
    chk("R1 start clears loaded", 32'(paletteLoaded), 32'd0);
    sendWord(32'h0000_0042);
    chk("R4 frameValid", 32'(frameValid), 32'd1);
    chk("R4 frameData", frameData, 32'h0000_0042);
    chk("R4 loaded stays low", 32'(paletteLoaded), 32'd0);
    pulseClr();
    chk("R8 clear ignored in mode 10", 32'(paletteLoaded), 32'd0);

    // reserved mode
    ctrlWrite(1'b1, 2'b11);
    sendWord(32'h7777_7777);
    chk("R1 mode 11 no frame", 32'(frameValid), 32'd0);
    chk("R1 mode 11 no load", 32'(paletteLoaded), 32'd0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule